// File: doc/BRIEF.md
# Byte-Wide SPI Target with Flag Handshake

This block is the target (slave) side of a serial peripheral link, seen by a processor through three byte-wide registers: control, status and data. The serial clock, the select line and the incoming data line come from an external controller. They pass through two-flop synchronizers and are oversampled in the system clock domain. The serial clock must therefore run slower than a quarter of the system clock. The block supports all four clock polarity and phase combinations. It returns a byte on its outgoing data line, most significant bit first.

Software loads the next byte to send by writing the data register. At the end of each byte the received value is copied into a read buffer and a completion flag is raised. That flag, together with the overrun and collision flags, is cleared by a two-step handshake: a status read, then a data read. While completion is pending and not yet acknowledged, writes to the data register are dropped. The interrupt request follows the completion flag, gated by an enable bit.

Register addresses on `bus_addr`: 0 control, 1 status, 2 data, 3 reads as zero. Control bits: 0 enable, 1 controller-mode select, 2 clock polarity, 3 clock phase, 4 interrupt enable, 6:5 rate field (stored, no effect), 7 reads 0. Status bits: 7 completion, 6 write collision, 5 overrun, 4:0 read 0.

Top module: `spi_tgt_top`

## Requirements
- R1: After reset the control, status and data registers read 0x00, `irq_out` is 0 and `miso_out` is 0.
- R2: With clock phase 0 the incoming bit is taken on the leading clock edge; with phase 1 it is taken on the trailing edge. The leading edge is the rising edge when polarity is 0 and the falling edge when polarity is 1. All four combinations transfer bytes correctly in both directions.
- R3: A data-register write loads the transmit register, which appears on `miso_out` MSB first. After a full byte the transmit register holds {byte[0], 7'b0}.
- R4: Bits move only while the select line is low, control bit 0 is 1 and control bit 1 is 0. Otherwise a byte clocked by the controller sets no flag.
- R5: On the eighth sampling edge, status bit 7 is set and the received byte enters the read buffer. A data-register read returns that buffer.
- R6: Status bits 7, 6 and 5 clear together only when a status read made while any of them is set is followed by a data read. A data read without that preceding status read leaves them set.
- R7: While status bit 7 is set and no status read has followed it, data-register writes are ignored.
- R8: A byte that completes while status bit 7 is still set sets status bit 5. The read buffer keeps the earlier byte, and a new status read is needed before the clearing data read.
- R9: `irq_out` is high exactly while status bit 7 and control bit 4 are both 1.
- R10: A data write while selected and enabled, with clock phase 0 or with a byte partly received, sets status bit 6 and is discarded.
- R11: If the select line rises part way through a byte, the bit count restarts at zero and no flag is set.
- R12: The rate field (control bits 6:5) has no effect on transfers.
- R13: If a byte completes in the same cycle as the clearing data read, that read returns the older byte. Status then reads 0x80 with no overrun, and the buffer holds the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on status and data) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sck_in | input | 1 | Serial clock from the controller |
| ss_n_in | input | 1 | Active-low select from the controller |
| mosi_in | input | 1 | Serial data into the block |
| miso_out | output | 1 | Serial data out of the block |
| irq_out | output | 1 | Interrupt request |

## Verification
The two functions that can share a cycle are the arrival of a byte's final sampling edge and the data read that finishes the clearing handshake. The bench arms the handshake with a status read after a first byte. It then places the data-register read on the exact system cycle in which the synchronized final edge of a second byte is recognised. The outcome is judged by three observations: the read returns the first byte, a following status read shows only the completion bit with no overrun, and the next acknowledged data read returns the second byte.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    localparam int BYTE_W = 8;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    typedef struct packed {
        logic       rsvd;
        logic [1:0] rate;
        logic       ie;
        logic       cpha;
        logic       cpol;
        logic       ctl_mode;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic       done;
        logic       wcol;
        logic       ovr;
        logic [4:0] zero;
    } stat_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;

    function automatic logic lead_edge(input logic cpol, input sck_edge_t e);
        return cpol ? e.fall : e.rise;
    endfunction

    function automatic logic trail_edge(input logic cpol, input sck_edge_t e);
        return cpol ? e.rise : e.fall;
    endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[LAST];

endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter
    import spi_tgt_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sck_s,
    input  logic          mosi_s,
    input  logic          active,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          ld_en,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] rx_word,
    output logic          complete,
    output logic          mid_byte,
    output logic          miso
);
    localparam int            CNTW = $clog2(DW);
    localparam logic [CNTW-1:0] LAST_BIT = CNTW'(DW - 1);

    logic            sck_q;
    logic [CNTW-1:0] cnt_q;
    logic [DW-1:0]   rx_q;
    logic [DW-1:0]   tx_q;
    sck_edge_t       edg;
    logic            samp_evt;
    logic            shift_evt;

    always_comb begin
        edg.rise  = sck_s & ~sck_q;
        edg.fall  = ~sck_s & sck_q;
        samp_evt  = active & (cpha ? trail_edge(cpol, edg) : lead_edge(cpol, edg));
        shift_evt = active & (cpha ? lead_edge(cpol, edg) : trail_edge(cpol, edg));
    end

    assign complete = samp_evt & (cnt_q == LAST_BIT);
    assign rx_word  = {rx_q[DW-2:0], mosi_s};
    assign mid_byte = (cnt_q != '0);
    assign miso     = tx_q[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cnt_q <= '0;
            rx_q  <= '0;
            tx_q  <= '0;
        end else begin
            sck_q <= sck_s;
            if (!active) begin
                cnt_q <= '0;
            end else if (samp_evt) begin
                rx_q  <= rx_word;
                cnt_q <= (cnt_q == LAST_BIT) ? '0 : cnt_q + CNTW'(1);
            end
            if (ld_en) begin
                tx_q <= ld_data;
            end else if (shift_evt && mid_byte) begin
                tx_q <= {tx_q[DW-2:0], 1'b0};
            end
        end
    end

    AST_DESELECT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt_q == '0)); // R11
    AST_TX_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!active && !ld_en) |=> $stable(tx_q)); // R4

endmodule

// File: rtl/spi_tgt_status.sv
module spi_tgt_status
    import spi_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              complete,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              stat_rd,
    input  logic              dr_rd,
    input  logic              dr_wr,
    input  logic              collide_cond,
    output stat_t             stat,
    output logic [BYTE_W-1:0] rbuf,
    output logic              load_en
);
    logic done_q, wcol_q, ovr_q, armed_q;
    logic [BYTE_W-1:0] buf_q;
    logic any_flag, clr, blocked, collision, take_rx, overrun;

    always_comb begin
        any_flag  = done_q | wcol_q | ovr_q;
        clr       = dr_rd & armed_q;
        blocked   = done_q & ~armed_q;
        collision = dr_wr & ~blocked & collide_cond;
        load_en   = dr_wr & ~blocked & ~collide_cond;
        take_rx   = complete & (~done_q | clr);
        overrun   = complete & done_q & ~clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            wcol_q  <= 1'b0;
            ovr_q   <= 1'b0;
            armed_q <= 1'b0;
            buf_q   <= '0;
        end else begin
            if (complete)       done_q <= 1'b1;
            else if (clr)       done_q <= 1'b0;
            if (collision)      wcol_q <= 1'b1;
            else if (clr)       wcol_q <= 1'b0;
            if (overrun)        ovr_q  <= 1'b1;
            else if (clr)       ovr_q  <= 1'b0;
            if (clr || complete)           armed_q <= 1'b0;
            else if (stat_rd && any_flag)  armed_q <= 1'b1;
            if (take_rx)        buf_q  <= rx_byte;
        end
    end

    assign stat = '{done: done_q, wcol: wcol_q, ovr: ovr_q, zero: 5'd0};
    assign rbuf = buf_q;

    AST_SECOND_BYTE_OVERRUNS: assert property (@(posedge clk) disable iff (rst)
        (complete && done_q && !clr) |=> ovr_q); // R8
    AST_BUFFER_KEEPS_OLDER: assert property (@(posedge clk) disable iff (rst)
        (complete && done_q && !clr) |=> $stable(buf_q)); // R8
    AST_CLEAR_NEEDS_SEQUENCE: assert property (@(posedge clk) disable iff (rst)
        $fell(done_q) |-> $past(dr_rd && armed_q)); // R6
    AST_COLLISION_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        collision |=> wcol_q); // R10
    AST_COMPLETE_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        complete |=> done_q); // R5

endmodule

// File: rtl/spi_tgt_top.sv
module spi_tgt_top
    import spi_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              sck_in,
    input  logic              ss_n_in,
    input  logic              mosi_in,
    output logic              miso_out,
    output logic              irq_out
);
    localparam int         PIN_W    = 3;
    localparam logic [2:0] PIN_RST  = 3'b010;

    ctrl_t             ctrl_q;
    stat_t             stat;
    logic [BYTE_W-1:0] rbuf;
    logic [PIN_W-1:0]  pins_s;
    logic              sck_s, ss_n_s, mosi_s;
    logic              active, mid_byte, complete, load_en, collide_cond;
    logic              stat_rd, dr_rd, dr_wr;
    logic [BYTE_W-1:0] rx_word;

    spi_tgt_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sck_in, ss_n_in, mosi_in}),
        .dout (pins_s)
    );
    assign {sck_s, ss_n_s, mosi_s} = pins_s;

    assign active       = ~ss_n_s & ctrl_q.en & ~ctrl_q.ctl_mode;
    assign collide_cond = active & (~ctrl_q.cpha | mid_byte);
    assign stat_rd      = bus_rd & (bus_addr == REG_STAT);
    assign dr_rd        = bus_rd & (bus_addr == REG_DATA);
    assign dr_wr        = bus_wr & (bus_addr == REG_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (bus_wr && bus_addr == REG_CTRL) begin
            ctrl_q      <= ctrl_t'(bus_wdata);
            ctrl_q.rsvd <= 1'b0;
        end
    end

    spi_tgt_shifter #(.DW(BYTE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (sck_s),
        .mosi_s   (mosi_s),
        .active   (active),
        .cpol     (ctrl_q.cpol),
        .cpha     (ctrl_q.cpha),
        .ld_en    (load_en),
        .ld_data  (bus_wdata),
        .rx_word  (rx_word),
        .complete (complete),
        .mid_byte (mid_byte),
        .miso     (miso_out)
    );

    spi_tgt_status u_stat (
        .clk          (clk),
        .rst          (rst),
        .complete     (complete),
        .rx_byte      (rx_word),
        .stat_rd      (stat_rd),
        .dr_rd        (dr_rd),
        .dr_wr        (dr_wr),
        .collide_cond (collide_cond),
        .stat         (stat),
        .rbuf         (rbuf),
        .load_en      (load_en)
    );

    always_comb begin
        unique case (bus_addr)
            REG_CTRL: bus_rdata = ctrl_q;
            REG_STAT: bus_rdata = stat;
            REG_DATA: bus_rdata = rbuf;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_out = stat.done & ctrl_q.ie;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> (stat.done && ctrl_q.ie)); // R9
    AST_NO_COMPLETE_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
        (ss_n_s || !ctrl_q.en || ctrl_q.ctl_mode) |-> !complete); // R4

endmodule

// File: tb/sim_spi_tgt_top.sv
module sim_spi_tgt_top;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic       miso, irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_tgt_top u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_in(sck), .ss_n_in(ss_n),
        .mosi_in(mosi), .miso_out(miso), .irq_out(irq)
    );

    function automatic logic [7:0] residue(input logic [7:0] t);
        return {t[0], 7'b0};
    endfunction

    function automatic logic [7:0] stat_val(input bit d, input bit w, input bit o);
        return {d, w, o, 5'b0};
    endfunction

    function automatic logic [7:0] ctrl_val(input bit ie, input bit cpha, input bit cpol,
                                            input bit cm, input bit en, input logic [1:0] rate);
        return {1'b0, rate, ie, cpha, cpol, cm, en};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic half_wait(input bit ovl, output logic [7:0] ovl_rd);
        if (ovl) begin
            @(negedge clk);
            @(negedge clk);
            bus_addr = 2'd2; bus_rd = 1'b1;
            #1 ovl_rd = bus_rdata;
            @(negedge clk);
            bus_rd = 1'b0;
            repeat (H - 3) @(negedge clk);
        end else begin
            repeat (H) @(negedge clk);
        end
    endtask

    task automatic xfer(input bit cpol, input bit cpha, input logic [7:0] mb, input int nbits,
                        input bit ovl, output logic [7:0] got, output logic [7:0] ovl_rd);
        got = 8'h00; ovl_rd = 8'h00;
        @(negedge clk);
        sck = cpol;
        repeat (4) @(negedge clk);
        ss_n = 1'b0;
        if (!cpha) mosi = mb[7];
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) begin
                sck = ~cpol;
                got = {got[6:0], miso};
                half_wait(ovl && i == 7, ovl_rd);
                sck = cpol;
                mosi = (i < 7) ? mb[6-i] : 1'b0;
                repeat (H) @(negedge clk);
            end else begin
                sck = ~cpol;
                mosi = mb[7-i];
                repeat (H) @(negedge clk);
                sck = cpol;
                got = {got[6:0], miso};
                half_wait(ovl && i == 7, ovl_rd);
            end
        end
        ss_n = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, got, ov, t, m, m2;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        cpu_rd(2'd0, r); chk("R1 ctrl", r, 8'h00);
        cpu_rd(2'd1, r); chk("R1 stat", r, 8'h00);
        cpu_rd(2'd2, r); chk("R1 data", r, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 miso", {7'b0, miso}, 8'h00);

        // R4: disabled, then controller-mode selected
        cpu_wr(2'd0, ctrl_val(0, 0, 0, 0, 0, 2'd0));
        xfer(0, 0, 8'h5A, 8, 0, got, ov);
        cpu_rd(2'd1, r); chk("R4 disabled", r, 8'h00);
        cpu_wr(2'd0, ctrl_val(0, 1, 1, 1, 1, 2'd0));
        xfer(1, 1, 8'h5A, 8, 0, got, ov);
        cpu_rd(2'd1, r); chk("R4 ctl_mode", r, 8'h00);

        // R2 R3 R5 R6 R9 R12 random transfers in all modes
        for (int it = 0; it < 32; it++) begin
            bit cpol, cpha, ie;
            logic [1:0] rate;
            cpol = 1'($urandom); cpha = 1'($urandom); ie = 1'($urandom); rate = 2'($urandom);
            t = 8'($urandom); m = 8'($urandom);
            cpu_wr(2'd0, ctrl_val(ie, cpha, cpol, 0, 1, rate));
            cpu_rd(2'd0, r); chk("R12 ctrl readback", r, ctrl_val(ie, cpha, cpol, 0, 1, rate));
            cpu_wr(2'd2, t);
            xfer(cpol, cpha, m, 8, 0, got, ov);
            chk("R2 R3 miso byte", got, t);
            chk("R9 irq set", {7'b0, irq}, {7'b0, ie});
            cpu_rd(2'd1, r); chk("R5 stat", r, stat_val(1, 0, 0));
            cpu_rd(2'd2, r); chk("R2 R5 rx byte", r, m);
            cpu_rd(2'd1, r); chk("R6 cleared", r, 8'h00);
            chk("R9 irq clear", {7'b0, irq}, 8'h00);
        end

        // R6: data read without status read keeps flag; R7 blocked write
        cpu_wr(2'd0, ctrl_val(1, 1, 0, 0, 1, 2'd3));
        cpu_wr(2'd2, 8'h01);
        xfer(0, 1, 8'hC3, 8, 0, got, ov);
        cpu_rd(2'd2, r); chk("R6 data only", r, 8'hC3);
        cpu_rd(2'd1, r); chk("R6 flag kept", r, stat_val(1, 0, 0));
        cpu_rd(2'd2, r);
        cpu_rd(2'd1, r); chk("R6 flag cleared", r, 8'h00);
        xfer(0, 1, 8'h11, 8, 0, got, ov);
        cpu_wr(2'd2, 8'hA5);
        cpu_rd(2'd1, r); cpu_rd(2'd2, r);
        xfer(0, 1, 8'h22, 8, 0, got, ov);
        chk("R7 write ignored", got, residue(8'h00));
        cpu_rd(2'd1, r); cpu_rd(2'd2, r);

        // R3 residue after a full byte
        cpu_wr(2'd2, 8'h81);
        xfer(0, 1, 8'h00, 8, 0, got, ov);
        cpu_rd(2'd1, r); cpu_rd(2'd2, r);
        xfer(0, 1, 8'h00, 8, 0, got, ov);
        chk("R3 residue", got, residue(8'h81));
        cpu_rd(2'd1, r); cpu_rd(2'd2, r);

        // R8 overrun
        cpu_wr(2'd0, ctrl_val(0, 0, 1, 0, 1, 2'd0));
        m = 8'h3E; m2 = 8'hB7;
        xfer(1, 0, m, 8, 0, got, ov);
        xfer(1, 0, m2, 8, 0, got, ov);
        cpu_rd(2'd1, r); chk("R8 overrun stat", r, stat_val(1, 0, 1));
        cpu_rd(2'd2, r); chk("R8 older kept", r, m);
        cpu_rd(2'd1, r); chk("R8 cleared", r, 8'h00);

        // R10 write collision with phase 0
        cpu_wr(2'd0, ctrl_val(0, 0, 0, 0, 1, 2'd0));
        cpu_wr(2'd2, 8'h96);
        @(negedge clk); ss_n = 1'b0;
        repeat (H) @(negedge clk);
        cpu_wr(2'd2, 8'h3C);
        cpu_rd(2'd1, r); chk("R10 wcol", r, stat_val(0, 1, 0));
        @(negedge clk); ss_n = 1'b1;
        repeat (H) @(negedge clk);
        cpu_rd(2'd2, r);
        cpu_rd(2'd1, r); chk("R10 wcol cleared", r, 8'h00);
        xfer(0, 0, 8'h00, 8, 0, got, ov);
        chk("R10 write discarded", got, 8'h96);
        cpu_rd(2'd1, r); cpu_rd(2'd2, r);

        // R11 abort mid-byte
        xfer(0, 0, 8'hFF, 4, 0, got, ov);
        cpu_rd(2'd1, r); chk("R11 no flag", r, 8'h00);
        xfer(0, 0, 8'h6D, 8, 0, got, ov);
        cpu_rd(2'd1, r);
        cpu_rd(2'd2, r); chk("R11 realigned", r, 8'h6D);

        // R13 completion in the same cycle as the clearing read
        cpu_wr(2'd0, ctrl_val(0, 1, 1, 0, 1, 2'd2));
        m = 8'h4B; m2 = 8'hD2;
        xfer(1, 1, m, 8, 0, got, ov);
        cpu_rd(2'd1, r); chk("R13 armed stat", r, stat_val(1, 0, 0));
        xfer(1, 1, m2, 8, 1, got, ov);
        chk("R13 read older", ov, m);
        cpu_rd(2'd1, r); chk("R13 no overrun", r, stat_val(1, 0, 0));
        cpu_rd(2'd2, r); chk("R13 new byte", r, m2);
        cpu_rd(2'd1, r); chk("R13 cleared", r, 8'h00);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule